// File: doc/BRIEF.md
# Disk DMA Sector Read Sequencer

This block is the device-side engine that serves a DMA read command arriving through a parallel disk task-file. The host writes the sector count, the three address bytes and the device/head byte, then writes the command byte. If the command is addressed to this unit and is the DMA read opcode, the sequencer does the following for each sector:

- It fetches the sector from a simple media port, which can report that the sector is unreadable.
- It streams the sector's 16-bit words to the host through a request/acknowledge handshake.
- It steps the address and lowers the count.

The starting address is either a 28-bit logical block number or a cylinder/head/sector triple. Bit 6 of the device byte selects which.

When the run ends, the block posts the final status and error bytes and raises a single interrupt pulse. A run ends when the last sector is sent, when a sector fails, or when the command is rejected. On a failure, the count and address registers are left pointing at the failing sector, so the host can see where the read stopped.

Top module: `ata_dma_read_seq`

## Requirements
- R1: Command bytes C8h and C9h both start the same read; opcode bit 0 has no effect on the transfer.
- R2: Any other command byte to a selected unit aborts the command. The error byte becomes 04h (abort, bit 2) and the status byte becomes 51h. One interrupt is raised, and no media request or DMA request occurs.
- R3: A command write whose device byte bit 4 differs from the DEV_ID parameter is ignored. Status stays unchanged, no interrupt is raised, and no media or DMA request occurs.
- R4: A count register value N in 1..255 transfers N sectors; a value of 0 transfers 256 sectors. The count register drops by one after each whole sector, so it reads 0 after a full run.
- R5: In logical mode (device bit 6 = 1), the media address is {device[3:0], high, mid, low}. It rises by one per sector, and the address registers end at start + sectors.
- R6: In cylinder/head/sector mode (device bit 6 = 0), low is the sector (1..SPT), {high, mid} is the cylinder and device[3:0] is the head. After sector SPT, the sector returns to 1 and the head advances. After head HEADS-1, the head returns to 0 and the cylinder increments.
- R7: Each sector delivers WORDS_PER_SECT words on dd_out, one per cycle in which dmarq and dmack are both high. The word is the media word presented at that time. dmarq is never high while the media is being asked for a sector.
- R8: BSY (status bit 7) reads 1 from the cycle after the command is accepted until the final status is posted. A successful run posts status 50h (RDY bit 6, DSC bit 4) and error 00h.
- R9: Every accepted or aborted command produces exactly one single-cycle intrq pulse. The pulse appears in the same cycle as the final status, so BSY is 0 during it.
- R10: An uncorrectable sector ends the run at that sector. The error byte becomes 40h (UNC, bit 6) and the status byte 51h (ERR, bit 0). Count and address registers hold the failing sector, and none of that sector's words are sent.
- R11: Register writes (select 0 count, 1 low, 2 mid, 3 high, 4 device, 5 command) are ignored while BSY is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tf_wr | input | 1 | Task-file register write strobe |
| tf_sel | input | 3 | Register select: 0 count, 1 low, 2 mid, 3 high, 4 device, 5 command |
| tf_wdata | input | 8 | Write data |
| rb_count | output | 8 | Current sector count register |
| rb_lba_lo | output | 8 | Current address low byte / sector number |
| rb_lba_mid | output | 8 | Current address mid byte / cylinder low |
| rb_lba_hi | output | 8 | Current address high byte / cylinder high |
| rb_dev | output | 8 | Device/head register |
| status | output | 8 | Status byte (BSY,RDY,DF,DSC,DRQ,COR,IDX,ERR from bit 7) |
| error | output | 8 | Error byte (CRC,UNC,0,IDN,0,ABT,T0N,AMN from bit 7) |
| intrq | output | 1 | One-cycle completion interrupt |
| med_req | output | 1 | Request for the sector at med_addr |
| med_addr | output | 28 | Current sector address, {head, high, mid, low} |
| med_chs | output | 1 | 1 when med_addr is a cylinder/head/sector triple |
| med_done | input | 1 | Media answer strobe for the pending request |
| med_bad | input | 1 | With med_done: sector is unreadable |
| med_data | input | 16 | Head-of-stream media word |
| med_pop | output | 1 | Media word consumed this cycle |
| dmarq | output | 1 | DMA request to host |
| dmack | input | 1 | DMA acknowledge from host |
| dd_out | output | 16 | Data word to host |

## Verification
The read runs in logical mode with count 3 and continuous acknowledge, with count 1 and toggling acknowledge, and with count 0 from address zero. These runs separate per-sector stepping, stall handling and the 256-sector meaning of zero. A low-byte carry start shows that the address increments as a whole 28-bit number rather than byte-wise. A cylinder/head/sector start near the end of both the sector and head ranges shows the two chained wraps. An unreadable third sector in a five-sector run shows where the block stops and what it leaves in the registers. A foreign opcode, a non-matching unit select and writes made while busy separate rejection, silence and write protection.

// File: rtl/ata_rd_pkg.sv
package ata_rd_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_XFER  = 2'd2,
    SQ_ADV   = 2'd3
  } seq_st_e;

  localparam logic [2:0] SEL_COUNT = 3'd0;
  localparam logic [2:0] SEL_LO    = 3'd1;
  localparam logic [2:0] SEL_MID   = 3'd2;
  localparam logic [2:0] SEL_HI    = 3'd3;
  localparam logic [2:0] SEL_DEV   = 3'd4;
  localparam logic [2:0] SEL_CMD   = 3'd5;

  localparam logic [7:0] STAT_OK  = 8'h50;
  localparam logic [7:0] STAT_ERR = 8'h51;
  localparam logic [7:0] ERR_UNC  = 8'h40;
  localparam logic [7:0] ERR_ABT  = 8'h04;

  // count register value -> number of sectors to move (0 stands for 256)
  function automatic logic [8:0] sect_total(input logic [7:0] c);
    return (c == 8'd0) ? 9'd256 : {1'b0, c};
  endfunction

  // read opcode check, bit 0 (retry) disregarded
  function automatic logic is_read_op(input logic [7:0] op);
    return op[7:1] == 7'b1100_100;
  endfunction

  function automatic logic [27:0] lba_step(input logic [27:0] a);
    return a + 28'd1;
  endfunction

  // a = {head[3:0], cyl[15:0], sec[7:0]}
  function automatic logic [27:0] chs_step(input logic [27:0] a,
                                           input logic [7:0]  spt,
                                           input logic [3:0]  hmax);
    logic [7:0]  s;
    logic [3:0]  h;
    logic [15:0] c;
    s = a[7:0];
    h = a[27:24];
    c = a[23:8];
    if (s >= spt) begin
      s = 8'd1;
      if (h >= hmax) begin
        h = 4'd0;
        c = c + 16'd1;
      end else begin
        h = h + 4'd1;
      end
    end else begin
      s = s + 8'd1;
    end
    return {h, c, s};
  endfunction

endpackage

// File: rtl/rd_addr_unit.sv
module rd_addr_unit #(
  parameter int SPT    = 63,
  parameter int HEADS  = 16,
  parameter bit CHS_EN = 1'b1
) (
  input  logic        chs_mode,
  input  logic [27:0] cur_addr,
  output logic [27:0] nxt_addr
);
  import ata_rd_pkg::*;

  localparam logic [7:0] SPT_L  = 8'(SPT);
  localparam logic [3:0] HMAX_L = 4'(HEADS - 1);

  generate
    if (CHS_EN) begin : g_chs
      always_comb begin
        if (chs_mode) nxt_addr = chs_step(cur_addr, SPT_L, HMAX_L);
        else          nxt_addr = lba_step(cur_addr);
      end
    end else begin : g_lba_only
      logic unused_mode;
      assign unused_mode = chs_mode;
      assign nxt_addr    = lba_step(cur_addr);
    end
  endgenerate

endmodule

// File: rtl/rd_word_pump.sv
module rd_word_pump #(
  parameter int WORDS_PER_SECT = 256,
  parameter int DATA_W         = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              dmack,
  input  logic [DATA_W-1:0] src_word,
  output logic              dmarq,
  output logic              pop,
  output logic              sect_end,
  output logic [DATA_W-1:0] word_out
);
  localparam int WCNT_W = (WORDS_PER_SECT > 1) ? $clog2(WORDS_PER_SECT) : 1;
  localparam logic [WCNT_W-1:0] LAST_W = WCNT_W'(WORDS_PER_SECT - 1);

  logic [WCNT_W-1:0] widx_q;

  assign dmarq    = run;
  assign pop      = run && dmack;
  assign sect_end = pop && (widx_q == LAST_W);
  assign word_out = src_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         widx_q <= '0;
    else if (!run)      widx_q <= '0;
    else if (sect_end)  widx_q <= '0;
    else if (pop)       widx_q <= widx_q + 1'b1;
  end

endmodule

// File: rtl/ata_dma_read_seq.sv
module ata_dma_read_seq #(
  parameter int WORDS_PER_SECT = 256,
  parameter int SPT            = 63,
  parameter int HEADS          = 16,
  parameter bit CHS_EN         = 1'b1,
  parameter bit DEV_ID         = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tf_wr,
  input  logic [2:0]  tf_sel,
  input  logic [7:0]  tf_wdata,
  output logic [7:0]  rb_count,
  output logic [7:0]  rb_lba_lo,
  output logic [7:0]  rb_lba_mid,
  output logic [7:0]  rb_lba_hi,
  output logic [7:0]  rb_dev,
  output logic [7:0]  status,
  output logic [7:0]  error,
  output logic        intrq,
  output logic        med_req,
  output logic [27:0] med_addr,
  output logic        med_chs,
  input  logic        med_done,
  input  logic        med_bad,
  input  logic [15:0] med_data,
  output logic        med_pop,
  output logic        dmarq,
  input  logic        dmack,
  output logic [15:0] dd_out
);
  import ata_rd_pkg::*;

  seq_st_e    st_q;
  logic [7:0] cnt_q, lo_q, mid_q, hi_q, dev_q;
  logic [7:0] stat_q, err_q;
  logic       irq_q;
  logic [8:0] left_q;

  logic        busy;
  logic        cmd_wr, dev_hit;
  logic        accept_evt, abort_evt, ignore_evt, fail_evt, adv_evt, sect_end;
  logic        last_sect;
  logic [27:0] cur_addr, nxt_addr;

  // named events for the checker
  assign busy       = (st_q != SQ_IDLE);
  assign cmd_wr     = tf_wr && (tf_sel == SEL_CMD) && !busy;
  assign dev_hit    = (dev_q[4] == DEV_ID);
  assign accept_evt = cmd_wr && dev_hit && is_read_op(tf_wdata);
  assign abort_evt  = cmd_wr && dev_hit && !is_read_op(tf_wdata);
  assign ignore_evt = cmd_wr && !dev_hit;
  assign fail_evt   = (st_q == SQ_FETCH) && med_done && med_bad;
  assign adv_evt    = (st_q == SQ_ADV);
  assign last_sect  = (left_q == 9'd1);

  assign cur_addr = {dev_q[3:0], hi_q, mid_q, lo_q};

  rd_addr_unit #(
    .SPT    (SPT),
    .HEADS  (HEADS),
    .CHS_EN (CHS_EN)
  ) u_addr (
    .chs_mode (!dev_q[6]),
    .cur_addr (cur_addr),
    .nxt_addr (nxt_addr)
  );

  rd_word_pump #(
    .WORDS_PER_SECT (WORDS_PER_SECT),
    .DATA_W         (16)
  ) u_pump (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (st_q == SQ_XFER),
    .dmack    (dmack),
    .src_word (med_data),
    .dmarq    (dmarq),
    .pop      (med_pop),
    .sect_end (sect_end),
    .word_out (dd_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= 8'd0;
      lo_q   <= 8'd0;
      mid_q  <= 8'd0;
      hi_q   <= 8'd0;
      dev_q  <= 8'hA0;
      stat_q <= STAT_OK;
      err_q  <= 8'd0;
      irq_q  <= 1'b0;
      left_q <= 9'd0;
    end else begin
      irq_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: begin
          if (tf_wr) begin
            unique case (tf_sel)
              SEL_COUNT: cnt_q <= tf_wdata;
              SEL_LO:    lo_q  <= tf_wdata;
              SEL_MID:   mid_q <= tf_wdata;
              SEL_HI:    hi_q  <= tf_wdata;
              SEL_DEV:   dev_q <= tf_wdata;
              default: ;
            endcase
          end
          if (accept_evt) begin
            st_q   <= SQ_FETCH;
            err_q  <= 8'd0;
            left_q <= sect_total(cnt_q);
          end else if (abort_evt) begin
            stat_q <= STAT_ERR;
            err_q  <= ERR_ABT;
            irq_q  <= 1'b1;
          end
        end
        SQ_FETCH: begin
          if (fail_evt) begin
            st_q   <= SQ_IDLE;
            stat_q <= STAT_ERR;
            err_q  <= ERR_UNC;
            irq_q  <= 1'b1;
          end else if (med_done) begin
            st_q <= SQ_XFER;
          end
        end
        SQ_XFER: begin
          if (sect_end) st_q <= SQ_ADV;
        end
        SQ_ADV: begin
          cnt_q  <= cnt_q - 8'd1;
          lo_q   <= nxt_addr[7:0];
          mid_q  <= nxt_addr[15:8];
          hi_q   <= nxt_addr[23:16];
          dev_q  <= {dev_q[7:4], nxt_addr[27:24]};
          left_q <= left_q - 9'd1;
          if (last_sect) begin
            st_q   <= SQ_IDLE;
            stat_q <= STAT_OK;
            irq_q  <= 1'b1;
          end else begin
            st_q <= SQ_FETCH;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign rb_count   = cnt_q;
  assign rb_lba_lo  = lo_q;
  assign rb_lba_mid = mid_q;
  assign rb_lba_hi  = hi_q;
  assign rb_dev     = dev_q;
  assign status     = busy ? {1'b1, 3'b000, dmarq, 3'b000} : stat_q;
  assign error      = err_q;
  assign intrq      = irq_q;
  assign med_req    = (st_q == SQ_FETCH);
  assign med_addr   = cur_addr;
  assign med_chs    = !dev_q[6];

endmodule

// File: rtl/ata_dma_read_seq_chk.sv
module ata_dma_read_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic [7:0] error,
  input logic [7:0] rb_count,
  input logic       intrq,
  input logic       dmarq,
  input logic       med_req,
  input logic       accept_evt,
  input logic       abort_evt,
  input logic       ignore_evt,
  input logic       fail_evt,
  input logic       adv_evt
);

  p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> intrq && error[2] && status[0] && !dmarq && !med_req)
    else $error("abort handling violated");

  p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ignore_evt |=> !intrq && !status[7] && !med_req)
    else $error("foreign unit command not ignored");

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> rb_count == $past(rb_count) - 8'd1)
    else $error("count not lowered per sector");

  p_no_req_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dmarq |-> !med_req)
    else $error("dma request during media fetch");

  p_dmarq_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dmarq |-> status[7])
    else $error("dma request without BSY");

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> status[7])
    else $error("BSY not raised on accept");

  p_irq_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
    intrq |-> !status[7])
    else $error("interrupt while busy");

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    intrq |=> !intrq)
    else $error("interrupt longer than one cycle");

  p_unc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> intrq && error[6] && status[0] && !dmarq)
    else $error("uncorrectable sector not reported");

endmodule

bind ata_dma_read_seq ata_dma_read_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .status     (status),
  .error      (error),
  .rb_count   (rb_count),
  .intrq      (intrq),
  .dmarq      (dmarq),
  .med_req    (med_req),
  .accept_evt (accept_evt),
  .abort_evt  (abort_evt),
  .ignore_evt (ignore_evt),
  .fail_evt   (fail_evt),
  .adv_evt    (adv_evt)
);

// File: tb/ata_dma_read_seq_test.sv
module ata_dma_read_seq_test;

  localparam int WPS   = 256;
  localparam int SPT   = 63;
  localparam int HEADS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tf_wr = 1'b0;
  logic [2:0]  tf_sel = 3'd0;
  logic [7:0]  tf_wdata = 8'd0;
  logic [7:0]  rb_count, rb_lba_lo, rb_lba_mid, rb_lba_hi, rb_dev, status, error;
  logic        intrq, med_req, med_chs, med_pop, dmarq;
  logic [27:0] med_addr;
  logic        med_done = 1'b0;
  logic        med_bad = 1'b0;
  logic [15:0] med_data;
  logic        dmack = 1'b0;
  logic [15:0] dd_out;

  int n_chk = 0;
  int n_bad = 0;

  // bench-side media / host model state
  logic [27:0] seen_addr = 28'd0;
  logic [15:0] widx = 16'd0;
  logic [27:0] addr_log [0:299];
  int  fetch_no = 0;
  int  base_fetch = 0;
  int  bad_idx = -1;
  int  stall_mode = 0;
  int  irq_cnt = 0;
  int  drq_cnt = 0;
  int  req_cnt = 0;
  int  word_cnt = 0;
  int  word_err = 0;

  always #10 clk = ~clk;

  ata_dma_read_seq #(.WORDS_PER_SECT(WPS), .SPT(SPT), .HEADS(HEADS)) uut (
    .clk(clk), .rst_n(rst_n), .tf_wr(tf_wr), .tf_sel(tf_sel), .tf_wdata(tf_wdata),
    .rb_count(rb_count), .rb_lba_lo(rb_lba_lo), .rb_lba_mid(rb_lba_mid),
    .rb_lba_hi(rb_lba_hi), .rb_dev(rb_dev), .status(status), .error(error),
    .intrq(intrq), .med_req(med_req), .med_addr(med_addr), .med_chs(med_chs),
    .med_done(med_done), .med_bad(med_bad), .med_data(med_data), .med_pop(med_pop),
    .dmarq(dmarq), .dmack(dmack), .dd_out(dd_out)
  );

  function automatic logic [15:0] pat(input logic [27:0] a, input logic [15:0] i);
    return {a[7:0] ^ i[7:0], a[15:8] + i[7:0]} ^ {4'h0, a[27:16]};
  endfunction

  assign med_data = pat(seen_addr, widx);

  always @(posedge clk) begin
    if (intrq)          irq_cnt  <= irq_cnt + 1;
    if (dmarq)          drq_cnt  <= drq_cnt + 1;
    if (med_req)        req_cnt  <= req_cnt + 1;
    if (dmarq && dmack) begin
      word_cnt <= word_cnt + 1;
      if (dd_out !== pat(seen_addr, widx)) word_err <= word_err + 1;
    end
    if (med_done)             widx <= 16'd0;
    else if (dmarq && dmack)  widx <= widx + 16'd1;
  end

  // media responder: answers a request three cycles after it appears
  initial begin
    int dly;
    dly = 0;
    forever begin
      @(negedge clk);
      if (med_done) begin
        med_done = 1'b0;
        med_bad  = 1'b0;
      end else if (med_req && rst_n) begin
        dly = dly + 1;
        if (dly == 3) begin
          dly = 0;
          seen_addr = med_addr;
          if (fetch_no < 300) addr_log[fetch_no] = med_addr;
          med_bad  = ((fetch_no - base_fetch) == bad_idx);
          med_done = 1'b1;
          fetch_no = fetch_no + 1;
        end
      end else begin
        dly = 0;
      end
    end
  end

  // host acknowledge driver
  initial begin
    forever begin
      @(negedge clk);
      if (stall_mode != 0) dmack = ~dmack;
      else                 dmack = 1'b1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    tf_wr = 1'b1; tf_sel = sel; tf_wdata = d;
    @(negedge clk);
    tf_wr = 1'b0;
  endtask

  task automatic load(input logic [7:0] cnt, input logic [7:0] dev,
                      input logic [7:0] lo, input logic [7:0] mid, input logic [7:0] hi);
    wr(3'd0, cnt); wr(3'd1, lo); wr(3'd2, mid); wr(3'd3, hi); wr(3'd4, dev);
  endtask

  task automatic wait_irq(input int base, input string tag);
    int t;
    t = 0;
    while (irq_cnt == base && t < 90000) begin
      @(negedge clk);
      t = t + 1;
    end
    if (irq_cnt == base) check({tag, " interrupt timeout"}, 0, 1);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [27:0] chs_expect(input logic [27:0] s, input int k);
    int lin;
    lin = ((int'(s[23:8]) * HEADS + int'(s[27:24])) * SPT) + int'(s[7:0]) - 1 + k;
    return {4'(((lin / SPT) % HEADS)), 16'(lin / (SPT * HEADS)), 8'((lin % SPT) + 1)};
  endfunction

  task automatic verify_addrs(input int n, input logic [27:0] s, input bit chs, input string tag);
    int errs;
    errs = 0;
    for (int k = 0; k < n; k++) begin
      logic [27:0] e;
      e = chs ? chs_expect(s, k) : s + 28'(k);
      if (addr_log[base_fetch + k] !== e) errs = errs + 1;
    end
    check({tag, " sector address sequence mismatches"}, errs, 0);
  endtask

  task automatic snap();
    base_fetch = fetch_no;
    word_cnt = 0; word_err = 0; drq_cnt = 0; req_cnt = 0;
  endtask

  task automatic t_reset();
    check("R8 reset status", status, 8'h50);
    check("R8 reset error", error, 8'h00);
    check("R9 reset intrq", intrq, 0);
    check("R7 reset dmarq", dmarq, 0);
  endtask

  // R1 R4 R5 R8 R11: logical mode, three sectors, write during busy
  task automatic t_lba3();
    int ib;
    snap(); bad_idx = -1; stall_mode = 0;
    load(8'd3, 8'hEA, 8'h56, 8'h34, 8'h12);
    ib = irq_cnt;
    wr(3'd5, 8'hC8);
    repeat (40) @(negedge clk);
    check("R8 BSY during run", status[7], 1);
    wr(3'd0, 8'h77);
    wr(3'd1, 8'h99);
    wait_irq(ib, "R1");
    check("R9 one interrupt C8 run", irq_cnt - ib, 1);
    check("R8 final status", status, 8'h50);
    check("R8 final error", error, 8'h00);
    check("R4 R11 count after run", rb_count, 8'h00);
    check("R5 R11 end address", {rb_dev[3:0], rb_lba_hi, rb_lba_mid, rb_lba_lo}, 28'hA123459);
    check("R7 word total", word_cnt, 3 * WPS);
    check("R7 word content errors", word_err, 0);
    verify_addrs(3, 28'hA123456, 0, "R5");
  endtask

  // R1 R5 R7: C9 opcode, carry across low byte, stalling acknowledge
  task automatic t_c9_carry();
    int ib;
    snap(); bad_idx = -1; stall_mode = 1;
    load(8'd1, 8'hE0, 8'hFF, 8'hFF, 8'h00);
    ib = irq_cnt;
    wr(3'd5, 8'hC9);
    wait_irq(ib, "R1");
    stall_mode = 0;
    check("R1 C9 status", status, 8'h50);
    check("R7 words with stalls", word_cnt, WPS);
    check("R7 stalled content errors", word_err, 0);
    check("R5 carry end address", {rb_lba_hi, rb_lba_mid, rb_lba_lo}, 24'h010000);
    check("R4 count one sector", rb_count, 0);
  endtask

  // R6: cylinder/head/sector wrap
  task automatic t_chs();
    int ib;
    snap(); bad_idx = -1; stall_mode = 0;
    load(8'd4, 8'hAF, 8'd62, 8'hFF, 8'h01);
    ib = irq_cnt;
    wr(3'd5, 8'hC8);
    wait_irq(ib, "R6");
    verify_addrs(4, {4'hF, 16'h01FF, 8'd62}, 1, "R6");
    check("R6 end sector", rb_lba_lo, 8'd3);
    check("R6 end head", rb_dev[3:0], 4'd0);
    check("R6 end cylinder", {rb_lba_hi, rb_lba_mid}, 16'h0200);
    check("R6 words", word_cnt, 4 * WPS);
  endtask

  // R4: count zero means 256
  task automatic t_full();
    int ib;
    snap(); bad_idx = -1; stall_mode = 0;
    load(8'd0, 8'hE0, 8'h00, 8'h00, 8'h00);
    ib = irq_cnt;
    wr(3'd5, 8'hC8);
    wait_irq(ib, "R4");
    check("R4 256 sector words", word_cnt, 256 * WPS);
    check("R4 fetch count", fetch_no - base_fetch, 256);
    check("R4 end address", {rb_lba_hi, rb_lba_mid, rb_lba_lo}, 24'h000100);
    check("R4 end count", rb_count, 0);
    check("R9 one interrupt long run", irq_cnt - ib, 1);
  endtask

  // R10: failing third sector
  task automatic t_unc();
    int ib;
    snap(); bad_idx = 2; stall_mode = 0;
    load(8'd5, 8'hE0, 8'h00, 8'h01, 8'h00);
    ib = irq_cnt;
    wr(3'd5, 8'hC8);
    wait_irq(ib, "R10");
    bad_idx = -1;
    check("R10 error byte", error, 8'h40);
    check("R10 status byte", status, 8'h51);
    check("R10 count at failing sector", rb_count, 8'd3);
    check("R10 address at failing sector", {rb_lba_hi, rb_lba_mid, rb_lba_lo}, 24'h000102);
    check("R10 words before failure", word_cnt, 2 * WPS);
    check("R9 one interrupt on failure", irq_cnt - ib, 1);
    // next good command clears the error
    ib = irq_cnt;
    load(8'd1, 8'hE0, 8'h00, 8'h00, 8'h00);
    wr(3'd5, 8'hC8);
    wait_irq(ib, "R8");
    check("R8 error cleared by next run", error, 8'h00);
    check("R8 status after recovery", status, 8'h50);
  endtask

  // R2: foreign opcode aborts
  task automatic t_abort();
    int ib;
    snap();
    load(8'd2, 8'hE0, 8'h10, 8'h00, 8'h00);
    ib = irq_cnt;
    wr(3'd5, 8'h20);
    repeat (20) @(negedge clk);
    check("R2 error abort", error, 8'h04);
    check("R2 status", status, 8'h51);
    check("R2 one interrupt", irq_cnt - ib, 1);
    check("R2 no dma request", drq_cnt, 0);
    check("R2 no media request", req_cnt, 0);
    check("R2 count untouched", rb_count, 8'd2);
  endtask

  // R3: command for the other unit
  task automatic t_other_unit();
    int ib;
    logic [7:0] st0;
    snap();
    load(8'd2, 8'hF0, 8'h10, 8'h00, 8'h00);
    st0 = status;
    ib = irq_cnt;
    wr(3'd5, 8'hC8);
    repeat (30) @(negedge clk);
    check("R3 status unchanged", status, st0);
    check("R3 no interrupt", irq_cnt - ib, 0);
    check("R3 no dma request", drq_cnt, 0);
    check("R3 no media request", req_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lba3();
    t_c9_carry();
    t_chs();
    t_abort();
    t_other_unit();
    t_unc();
    t_full();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk = n_chk + 1;
    n_bad = n_bad + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule